// File: doc/BRIEF.md
# Embedded operations channel framer

This block carries 12-bit operations messages over three overhead bit positions (M1, M2 and M3) of a framed line signal. Eight frames make a superframe and each half of a superframe (four frames) carries one whole message, so two messages travel per superframe. Each message holds a 3-bit destination address in bits 11:9, a data-mode flag in bit 8 (encoded message or raw data) and an information byte in bits 7:0.

On transmit the host writes a message into a transmit register. At the start of each half-superframe that register is copied into a working word. The word's bits are then sent three per frame, most significant bit first: M1, M2 and M3 of the first frame, then the next frame, and so on. On receive the block gathers the three bits offered in each frame's overhead slot. When the fourth frame's slot arrives, it hands the complete word to the host with a one-cycle valid pulse. The block does not interpret the address or mode fields. When an encoded command arrives, the host must act on it separately.

Frame timing comes from outside the block. A frame-start pulse marks each frame. A superframe-start pulse, given together with a frame-start pulse, marks frame 0 of a superframe. A slot strobe marks the cycle in which the received M bits are valid.

Top module: `eoc_framer`

## Requirements
- R1: In frame p (0..3) of a half-superframe, `tx_m_bits` equals bits [11-3p : 9-3p] of the message being sent, with M1 on `tx_m_bits[2]`, M2 on `[1]` and M3 on `[0]`. The address goes out first and the information byte last.
- R2: `tx_m_bits` changes only in the cycle after a `frame_start` pulse and holds for the rest of the frame.
- R3: The transmit register is copied at every half-superframe start. A host write during a half takes effect at the next half. A write in the same cycle as a half start also takes effect at the next half. With no new write, the previous message is sent again.
- R4: Each accepted slot strobe stores `rx_m_bits` at that frame's position in the word, using the same bit order as R1. In the cycle after the fourth frame's strobe, `rx_msg` holds the whole 12-bit word and `rx_valid` is high for exactly one cycle. `rx_msg` changes only together with `rx_valid`.
- R5: Half-superframes begin at frames 0 and 4. Frame numbering wraps from 7 to 0 without a new superframe-start pulse, so each superframe carries two messages.
- R6: `superframe_start` together with `frame_start` sets the frame number to 0 at any time. It reloads the transmit word from the transmit register and discards any partly received message.
- R7: After reset, `tx_m_bits`, `rx_msg` and `rx_valid` are 0. Until the first superframe start, `tx_m_bits` stays 0, frame pulses and strobes are ignored, and `rx_valid` stays low.
- R8: A second slot strobe within the same frame has no effect. A strobe in the same cycle as `frame_start` also has no effect.
- R9: A half-superframe in which any frame lacked an accepted strobe produces no `rx_valid`, and `rx_msg` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| superframe_start | input | 1 | High with frame_start on frame 0 of a superframe |
| slot_strobe | input | 1 | Received overhead bits are valid this cycle |
| rx_m_bits | input | 3 | Received M1, M2, M3 bits (M1 in bit 2) |
| tx_wr | input | 1 | Host write strobe for the transmit register |
| tx_data | input | 12 | Message written to the transmit register |
| tx_m_bits | output | 3 | M1, M2, M3 bits to send in the current frame (M1 in bit 2) |
| rx_msg | output | 12 | Last complete received message |
| rx_valid | output | 1 | One-cycle pulse when rx_msg has been updated |

## Verification
The hardest case to reach is a receive half that is cut short or spoiled: one frame missing its strobe, extra strobes in a frame, or a superframe start arriving in the middle of a half. From the ports alone, such a half looks the same as a good one that simply never finished. The stimulus reaches these cases by replaying full halves with chosen strobe masks, by adding strobes in the frame-start cycle and after the real strobe, and by issuing two partial frames before a fresh superframe start. A scoreboard queue of expected words then shows that nothing was delivered from the damaged half. The host transmit register is also written in the middle of a half and just before a realignment, to show when the new value reaches the line.

// File: rtl/eoc_framer.sv
module eoc_framer #(
  parameter int BITS_PER_FRAME  = 3,
  parameter int FRAMES_PER_HALF = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      frame_start,
  input  logic                                      superframe_start,
  input  logic                                      slot_strobe,
  input  logic [BITS_PER_FRAME-1:0]                 rx_m_bits,
  input  logic                                      tx_wr,
  input  logic [BITS_PER_FRAME*FRAMES_PER_HALF-1:0] tx_data,
  output logic [BITS_PER_FRAME-1:0]                 tx_m_bits,
  output logic [BITS_PER_FRAME*FRAMES_PER_HALF-1:0] rx_msg,
  output logic                                      rx_valid
);
  localparam int MSG_W = BITS_PER_FRAME * FRAMES_PER_HALF;
  localparam int PW    = $clog2(FRAMES_PER_HALF);
  localparam int FW    = PW + 1;
  localparam int LW    = $clog2(MSG_W);

  logic                       synced, slot_done;
  logic [FW-1:0]              fidx, fidx_n;
  logic [PW-1:0]              pos;
  logic [MSG_W-1:0]           tx_reg, tx_cur, acc, acc_n;
  logic [FRAMES_PER_HALF-1:0] got, got_n;
  logic [LW-1:0]              lsb;
  logic                       sf_hit, half_begin, cap, last_slot;

  assign sf_hit     = frame_start & superframe_start;
  assign fidx_n     = sf_hit ? '0 : fidx + 1'b1;
  assign half_begin = frame_start & (sf_hit | (synced & (fidx_n[PW-1:0] == '0)));
  assign pos        = fidx[PW-1:0];
  assign lsb        = LW'(MSG_W - BITS_PER_FRAME * (int'(pos) + 1));
  assign cap        = slot_strobe & synced & ~slot_done & ~frame_start;
  assign last_slot  = pos == PW'(FRAMES_PER_HALF - 1);
  assign got_n      = got | (FRAMES_PER_HALF'(1) << pos);
  assign tx_m_bits  = synced ? tx_cur[lsb +: BITS_PER_FRAME] : '0;

  always_comb begin
    acc_n = acc;
    acc_n[lsb +: BITS_PER_FRAME] = rx_m_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced    <= 1'b0;
      slot_done <= 1'b0;
      fidx      <= '0;
      tx_reg    <= '0;
      tx_cur    <= '0;
      acc       <= '0;
      got       <= '0;
      rx_msg    <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tx_wr) tx_reg <= tx_data;
      if (frame_start && (synced || sf_hit)) begin
        synced    <= 1'b1;
        fidx      <= fidx_n;
        slot_done <= 1'b0;
      end
      if (half_begin) begin
        tx_cur <= tx_reg;
        got    <= '0;
      end
      if (cap) begin
        acc       <= acc_n;
        got       <= got_n;
        slot_done <= 1'b1;
        if (last_slot && (&got_n)) begin
          rx_msg   <= acc_n;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(tx_m_bits));

  p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_msg));

  p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_valid_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(slot_strobe));

  p_realign_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sf_hit |=> tx_m_bits == $past(tx_reg[MSG_W-1 -: BITS_PER_FRAME]));

  p_quiet_unsynced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (tx_m_bits == '0) && !rx_valid);

  p_extra_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && slot_strobe && !frame_start) |=> $stable(rx_msg) && !rx_valid);
endmodule

// File: tb/sim_eoc_framer.sv
`timescale 1ns/1ps
module sim_eoc_framer;
  localparam int B = 3;
  localparam int F = 4;
  localparam int W = B * F;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, frame_start, superframe_start, slot_strobe, tx_wr, rx_valid;
  logic [B-1:0] rx_m_bits, tx_m_bits;
  logic [W-1:0] tx_data, rx_msg;

  eoc_framer #(.BITS_PER_FRAME(B), .FRAMES_PER_HALF(F)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .superframe_start(superframe_start), .slot_strobe(slot_strobe),
    .rx_m_bits(rx_m_bits), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_m_bits(tx_m_bits), .rx_msg(rx_msg), .rx_valid(rx_valid));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];

  bit           m_sync = 0;
  int           m_fidx = 0;
  logic [W-1:0] m_reg = '0, m_cur = '0, m_acc = '0;
  logic [F-1:0] m_got = '0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic host_write(input logic [W-1:0] v);
    @(negedge clk); tx_wr = 1'b1; tx_data = v;
    @(negedge clk); tx_wr = 1'b0;
    m_reg = v;
  endtask

  task automatic frame(input bit sf, input logic [B-1:0] bits, input bit strobe, input bit extra);
    int p;
    logic [B-1:0] e;
    @(negedge clk);
    frame_start = 1'b1; superframe_start = sf;
    if (extra) begin slot_strobe = 1'b1; rx_m_bits = ~bits; end
    if (sf) begin m_sync = 1; m_fidx = 0; end
    else if (m_sync) m_fidx = (m_fidx + 1) % (2 * F);
    if (m_sync && (m_fidx % F == 0)) begin m_cur = m_reg; m_got = '0; end
    p = m_fidx % F;
    @(negedge clk);
    frame_start = 1'b0; superframe_start = 1'b0; slot_strobe = 1'b0;
    e = m_sync ? m_cur[W-B*(p+1) +: B] : '0;
    chk(m_sync ? "R1 R3 R5 tx slot bits" : "R7 tx bits before sync", W'(tx_m_bits), W'(e));
    if (strobe) begin
      slot_strobe = 1'b1; rx_m_bits = bits;
      if (m_sync) begin
        m_acc[W-B*(p+1) +: B] = bits;
        m_got[p] = 1'b1;
        if (p == F - 1 && (&m_got)) exp_q.push_back(m_acc);
      end
      @(negedge clk); slot_strobe = 1'b0;
      if (extra) begin
        slot_strobe = 1'b1; rx_m_bits = ~bits;
        @(negedge clk); slot_strobe = 1'b0;
      end
    end
    @(negedge clk);
    chk("R2 tx bits held within frame", W'(tx_m_bits), W'(e));
  endtask

  task automatic run_half(input bit sf, input logic [W-1:0] rxw, input logic [F-1:0] smask, input bit extra);
    for (int k = 0; k < F; k++)
      frame(sf && (k == 0), rxw[W-B*(k+1) +: B], smask[k], extra);
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && rx_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected rx_valid: actual %h expected none", rx_msg);
      end else begin
        chk("R4 received message", rx_msg, exp_q.pop_front());
      end
    end
  end

  initial begin
    logic [W-1:0] saved;
    rst_n = 1'b0; frame_start = 0; superframe_start = 0; slot_strobe = 0;
    tx_wr = 0; tx_data = '0; rx_m_bits = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset tx_m_bits", W'(tx_m_bits), '0);
    chk("R7 reset rx_msg", rx_msg, '0);
    chk("R7 reset rx_valid", W'(rx_valid), '0);
    rst_n = 1'b1;

    frame(0, 3'b101, 1, 0);
    frame(0, 3'b011, 1, 0);
    chk("R7 no rx before sync", rx_msg, '0);

    host_write(12'hA5C);
    run_half(1, 12'h3C9, 4'hF, 0);
    run_half(0, 12'h8F1, 4'hF, 0);

    frame(0, 3'b110, 1, 0);
    host_write(12'h1E7);
    frame(0, 3'b001, 1, 0);
    frame(0, 3'b111, 1, 0);
    frame(0, 3'b010, 1, 0);

    run_half(0, 12'h5A3, 4'hF, 1);

    saved = rx_msg;
    run_half(0, 12'h777, 4'b1011, 0);
    chk("R9 rx_msg kept after missing slot", rx_msg, saved);

    frame(0, 3'b100, 1, 0);
    frame(0, 3'b100, 1, 0);
    host_write(12'h2D4);
    run_half(1, 12'hC0F, 4'hF, 0);
    run_half(0, 12'h1FE, 4'hF, 0);

    repeat (4) @(negedge clk);
    chk("R4 all expected messages delivered", W'(exp_q.size()), '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule